// File: doc/BRIEF.md
# Prioritized Interrupt Controller with DMA Request Routing

This block gathers a parameterized number of asynchronous interrupt request lines. A set of configuration registers controls each source. They choose the event that counts as a request: high level, low level, rising edge, falling edge or either edge. They also give the source a priority level from 0 to 7. The block selects a single winning source and presents it to the processor as a registered request. The request carries a valid bit, the source index and the source's level. A global threshold holds back every request whose level does not exceed it.

Any source can be switched from interrupt duty to DMA duty. In DMA duty, a satisfied trigger condition sets a request flag for the DMA channel chosen in that source's configuration, and the source no longer takes part in interrupt arbitration. The flags drive the DMA request outputs. Software can read the flags and clear them by writing ones. Edge-detected interrupt requests are held in sticky pending bits, and software clears them in the same write-one-to-clear way.

Top module: `intc_top`

## Requirements
- R1: The trigger mode field (config bits [2:0]) selects the trigger: 0 = input high, 1 = input low, 2 = rising edge, 3 = falling edge, 4 = either edge. Codes 5 to 7 never trigger.
- R2: The level field (config bits [6:4]) gives the priority, 1 to 7, with 7 the highest. A source at level 0 is disabled: it never becomes pending and never sets a DMA flag.
- R3: Among forwarded requests, the highest level wins. When levels are equal, the lowest source index wins.
- R4: The threshold register (address NSRC, bits [2:0]) resets to 0. A request is forwarded only when its level is strictly greater than the threshold, so a threshold of 7 blocks everything.
- R5: `irq_valid`, `irq_id` and `irq_level` are registered and follow the arbitration one clock later. When no request is forwarded, all three are 0.
- R6: An edge-mode source sets a sticky pending bit on its edge, and the bit stays set until software clears it. A level-mode source requests only while its input holds the active level. Address NSRC+2 reads the per-source request vector, and writing 1 to bit i clears the pending bit of source i.
- R7: When the DMA bit (config bit 8) is set, a satisfied trigger sets the DMA flag of the channel given in config bits [12 +: log2(NCH)], and the source raises no interrupt.
- R8: The DMA flags are read at address NSRC+1 and driven on `dma_req`. Writing 1 to a bit clears that flag. A clear wins over a set in the same cycle.
- R9: A pending-clear write that lands in the same cycle as a new edge wins, and that edge is lost.
- R10: Addresses 0 to NSRC-1 hold the per-source configuration words, and those words read back exactly as they were written.
- R11: After reset, every configuration word, the threshold, all pending bits, all DMA flags and the interrupt outputs are 0.
- R12: Each input passes through two synchronizer flops. A level-mode request shows on `irq_valid` on the third rising clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NSRC | Raw asynchronous request lines |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq_valid | output | 1 | A forwarded interrupt request exists |
| irq_id | output | log2(NSRC) | Index of the winning source |
| irq_level | output | 3 | Level of the winning source |
| dma_req | output | NCH | Pending DMA transfer request flags |

## Verification
The assertions assume that the raw inputs are low while reset is asserted. They also assume that a register write lasts exactly one strobed cycle. An input change must be held for several clocks, because a pulse narrower than a clock period may never reach the synchronizer. The stimulus keeps to these limits: inputs rest at 0 through reset, each register write is a single-cycle strobe, and every random input change is held for at least four clocks. One directed sequence places a pending-clear write on exactly the edge where a new edge would latch.

// File: rtl/intc_pkg.sv
// Package: shared encodings and register field positions for the interrupt
// controller. Assumes a 32-bit register data path.
package intc_pkg;

    typedef enum logic [2:0] {
        TRIG_HIGH = 3'd0,
        TRIG_LOW  = 3'd1,
        TRIG_RISE = 3'd2,
        TRIG_FALL = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_e;

    localparam int LVL_W        = 3;
    localparam int MODE_W       = 3;
    localparam int DW           = 32;
    localparam int FLD_MODE_LSB = 0;
    localparam int FLD_LVL_LSB  = 4;
    localparam int FLD_DMA_BIT  = 8;
    localparam int FLD_CHAN_LSB = 12;

endpackage

// File: rtl/intc_src.sv
// Module: one interrupt source. It synchronizes the raw line, evaluates the
// selected trigger and keeps a sticky pending bit for the edge modes.
// Assumes: mode/enable/dma inputs are quasi-static; clr is a one-cycle pulse.
module intc_src
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_raw,
    input  logic [MODE_W-1:0] mode,
    input  logic              enabled,
    input  logic              dma_en,
    input  logic              clr,
    output logic              req,
    output logic              dma_hit,
    output logic              pend_o
);

    logic sync1_q, sync2_q, prev_q, pend_q;
    logic rise, fall, edge_evt, lvl_act, is_edge;

    // Two-flop synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= irq_raw;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign rise = sync2_q & ~prev_q;
    assign fall = ~sync2_q & prev_q;

    // Decode the trigger mode into a level condition or an edge event.
    always_comb begin
        lvl_act  = 1'b0;
        edge_evt = 1'b0;
        is_edge  = 1'b0;
        case (mode)
            TRIG_HIGH: lvl_act = sync2_q;
            TRIG_LOW:  lvl_act = ~sync2_q;
            TRIG_RISE: begin is_edge = 1'b1; edge_evt = rise; end
            TRIG_FALL: begin is_edge = 1'b1; edge_evt = fall; end
            TRIG_BOTH: begin is_edge = 1'b1; edge_evt = rise | fall; end
            default:   ;
        endcase
    end

    // Sticky pending bit; a software clear beats a same-cycle edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (clr) begin
            pend_q <= 1'b0;
        end else if (enabled && !dma_en && edge_evt) begin
            pend_q <= 1'b1;
        end
    end

    assign req     = enabled & ~dma_en & (is_edge ? pend_q : lvl_act);
    assign dma_hit = enabled & dma_en & (is_edge ? edge_evt : lvl_act);
    assign pend_o  = pend_q;

endmodule

// File: rtl/intc_arb.sv
// Module: combinational priority pick. Highest level above the threshold
// wins; among equal levels the lowest index wins.
// Assumes: NSRC >= 2.
module intc_arb
    import intc_pkg::*;
#(
    parameter int NSRC = 8,
    localparam int IDW = $clog2(NSRC)
)(
    input  logic [NSRC-1:0]             req,
    input  logic [NSRC-1:0][LVL_W-1:0]  lvl,
    input  logic [LVL_W-1:0]            thresh,
    output logic                        win_valid,
    output logic [IDW-1:0]              win_id,
    output logic [LVL_W-1:0]            win_level
);

    // Scan from the top index down so that ties settle on the lower index.
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_level = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i] && (lvl[i] > thresh) && (lvl[i] >= win_level)) begin
                win_valid = 1'b1;
                win_id    = IDW'(i);
                win_level = lvl[i];
            end
        end
    end

endmodule

// File: rtl/intc_dma_flags.sv
// Module: DMA request flag register. Each source hit sets the flag of its
// channel; software clears flags with ones. Clear wins over set.
// Assumes: NCH >= 2.
module intc_dma_flags #(
    parameter int NSRC = 8,
    parameter int NCH  = 4,
    localparam int CHW = $clog2(NCH)
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSRC-1:0]            hit,
    input  logic [NSRC-1:0][CHW-1:0]   chan,
    input  logic [NCH-1:0]             clr,
    output logic [NCH-1:0]             flags
);

    logic [NCH-1:0] set_vec;

    // Gather hits per channel.
    always_comb begin
        set_vec = '0;
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < NSRC; s++) begin
                if (hit[s] && (chan[s] == CHW'(c))) begin
                    set_vec[c] = 1'b1;
                end
            end
        end
    end

    // Flag update, clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags | set_vec) & ~clr;
        end
    end

endmodule

// File: rtl/intc_top.sv
// Module: interrupt controller top. It holds the configuration registers,
// the threshold register and the register decode, instantiates one source
// per input, arbitrates, and registers the winning request.
// Assumes: one-cycle write strobes; NSRC <= 32, 2 <= NCH <= 16.
module intc_top
    import intc_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int NCH  = 4,
    parameter int AW   = 8
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC-1:0]          irq_in,
    input  logic                     reg_we,
    input  logic [AW-1:0]            reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic                     irq_valid,
    output logic [$clog2(NSRC)-1:0]  irq_id,
    output logic [2:0]               irq_level,
    output logic [NCH-1:0]           dma_req
);

    localparam int IDW = $clog2(NSRC);
    localparam int CHW = $clog2(NCH);
    localparam logic [AW-1:0] A_THRESH = AW'(NSRC);
    localparam logic [AW-1:0] A_DMA    = AW'(NSRC + 1);
    localparam logic [AW-1:0] A_PEND   = AW'(NSRC + 2);

    logic [NSRC-1:0][MODE_W-1:0] cfg_mode;
    logic [NSRC-1:0][LVL_W-1:0]  cfg_lvl;
    logic [NSRC-1:0]             cfg_dma;
    logic [NSRC-1:0][CHW-1:0]    cfg_chan;
    logic [LVL_W-1:0]            thresh_q;

    logic [NSRC-1:0] src_req, src_hit, pend_vec, pend_clr;
    logic [NCH-1:0]  dma_clr, dma_flags;
    logic            win_valid;
    logic [IDW-1:0]  win_id;
    logic [LVL_W-1:0] win_level;
    logic [IDW-1:0]  rd_sel;
    logic            wdata_unused;

    assign wdata_unused = ^reg_wdata;

    // Configuration and threshold register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_mode <= '0;
            cfg_lvl  <= '0;
            cfg_dma  <= '0;
            cfg_chan <= '0;
            thresh_q <= '0;
        end else if (reg_we) begin
            for (int i = 0; i < NSRC; i++) begin
                if (reg_addr == AW'(i)) begin
                    cfg_mode[i] <= reg_wdata[FLD_MODE_LSB +: MODE_W];
                    cfg_lvl[i]  <= reg_wdata[FLD_LVL_LSB +: LVL_W];
                    cfg_dma[i]  <= reg_wdata[FLD_DMA_BIT];
                    cfg_chan[i] <= reg_wdata[FLD_CHAN_LSB +: CHW];
                end
            end
            if (reg_addr == A_THRESH) begin
                thresh_q <= reg_wdata[LVL_W-1:0];
            end
        end
    end

    // Write-one-to-clear strobes for pending bits and DMA flags.
    assign pend_clr = (reg_we && reg_addr == A_PEND) ? reg_wdata[NSRC-1:0] : '0;
    assign dma_clr  = (reg_we && reg_addr == A_DMA)  ? reg_wdata[NCH-1:0]  : '0;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        intc_src u_src (
            .clk     (clk),
            .rst_n   (rst_n),
            .irq_raw (irq_in[g]),
            .mode    (cfg_mode[g]),
            .enabled (cfg_lvl[g] != '0),
            .dma_en  (cfg_dma[g]),
            .clr     (pend_clr[g]),
            .req     (src_req[g]),
            .dma_hit (src_hit[g]),
            .pend_o  (pend_vec[g])
        );
    end

    intc_arb #(.NSRC(NSRC)) u_arb (
        .req       (src_req),
        .lvl       (cfg_lvl),
        .thresh    (thresh_q),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_level (win_level)
    );

    intc_dma_flags #(.NSRC(NSRC), .NCH(NCH)) u_dma (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (src_hit),
        .chan  (cfg_chan),
        .clr   (dma_clr),
        .flags (dma_flags)
    );

    assign dma_req = dma_flags;

    // Registered interrupt request toward the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_id    <= '0;
            irq_level <= '0;
        end else begin
            irq_valid <= win_valid;
            irq_id    <= win_id;
            irq_level <= win_level;
        end
    end

    assign rd_sel = reg_addr[IDW-1:0];

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) < NSRC) begin
            reg_rdata[FLD_MODE_LSB +: MODE_W] = cfg_mode[rd_sel];
            reg_rdata[FLD_LVL_LSB +: LVL_W]   = cfg_lvl[rd_sel];
            reg_rdata[FLD_DMA_BIT]            = cfg_dma[rd_sel];
            reg_rdata[FLD_CHAN_LSB +: CHW]    = cfg_chan[rd_sel];
        end else if (reg_addr == A_THRESH) begin
            reg_rdata[LVL_W-1:0] = thresh_q;
        end else if (reg_addr == A_DMA) begin
            reg_rdata[NCH-1:0] = dma_flags;
        end else if (reg_addr == A_PEND) begin
            reg_rdata[NSRC-1:0] = src_req;
        end
    end

endmodule

// File: rtl/intc_chk.sv
// Module: assertion checker bound to intc_top. Observes the arbiter, the
// pending bits, the DMA flags and the registered outputs.
module intc_chk #(
    parameter int NSRC = 8,
    parameter int NCH  = 4,
    localparam int IDW = $clog2(NSRC)
)(
    input logic             clk,
    input logic             rst_n,
    input logic             irq_valid,
    input logic [IDW-1:0]   irq_id,
    input logic [2:0]       irq_level,
    input logic [2:0]       thresh_q,
    input logic             win_valid,
    input logic [IDW-1:0]   win_id,
    input logic [2:0]       win_level,
    input logic [NSRC-1:0]  cfg_dma,
    input logic [NSRC-1:0]  pend_vec,
    input logic [NSRC-1:0]  pend_clr,
    input logic [NCH-1:0]   dma_flags,
    input logic [NCH-1:0]   dma_clr
);

    a_r2_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> irq_level != 3'd0);

    a_r4_above_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> win_level > thresh_q);

    a_r7_no_irq_in_dma: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> !cfg_dma[win_id]);

    a_r5_registered: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> irq_valid && irq_id == $past(win_id) && irq_level == $past(win_level));

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> irq_id == '0 && irq_level == 3'd0);

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr != '0 |=> (pend_vec & $past(pend_clr)) == '0);

    a_r8_flag_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        dma_clr != '0 |=> (dma_flags & $past(dma_clr)) == '0);

endmodule

bind intc_top intc_chk #(.NSRC(NSRC), .NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_valid (irq_valid),
    .irq_id    (irq_id),
    .irq_level (irq_level),
    .thresh_q  (thresh_q),
    .win_valid (win_valid),
    .win_id    (win_id),
    .win_level (win_level),
    .cfg_dma   (cfg_dma),
    .pend_vec  (pend_vec),
    .pend_clr  (pend_clr),
    .dma_flags (dma_flags),
    .dma_clr   (dma_clr)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;

    localparam int NSRC = 8;
    localparam int NCH  = 4;
    localparam int AW   = 8;
    localparam int A_THR  = NSRC;
    localparam int A_DMA  = NSRC + 1;
    localparam int A_PEND = NSRC + 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_in = '0;
    logic            reg_we = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq_valid;
    logic [2:0]      irq_id;
    logic [2:0]      irq_level;
    logic [NCH-1:0]  dma_req;

    int checks = 0;
    int errors = 0;

    // Bench-side model state
    int  m_mode [NSRC];
    int  m_lvl  [NSRC];
    int  m_dma  [NSRC];
    int  m_chan [NSRC];
    int  m_thr;
    bit  drv    [NSRC];
    logic [NSRC-1:0] exp_pend;
    logic [NCH-1:0]  exp_dma;

    always #4 clk = ~clk;

    intc_top #(.NSRC(NSRC), .NCH(NCH), .AW(AW)) dut (
        .clk, .rst_n, .irq_in, .reg_we, .reg_addr, .reg_wdata,
        .reg_rdata, .irq_valid, .irq_id, .irq_level, .dma_req
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic reg_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(addr); reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input int addr, output logic [31:0] data);
        @(negedge clk);
        reg_addr = AW'(addr);
        #1 data = reg_rdata;
    endtask

    function automatic bit is_edge_mode(int m);
        return m >= 2 && m <= 4;
    endfunction

    function automatic bit level_active(int i);
        if (m_mode[i] == 0) return drv[i];
        if (m_mode[i] == 1) return !drv[i];
        return 1'b0;
    endfunction

    function automatic bit edge_matches(int m, bit o, bit n);
        if (o == n) return 1'b0;
        if (m == 2) return n;
        if (m == 3) return !n;
        return m == 4;
    endfunction

    function automatic logic [NSRC-1:0] exp_req();
        logic [NSRC-1:0] r = '0;
        for (int i = 0; i < NSRC; i++)
            if (m_lvl[i] != 0 && m_dma[i] == 0)
                r[i] = is_edge_mode(m_mode[i]) ? exp_pend[i] : level_active(i);
        return r;
    endfunction

    // Expected output word {valid, id, level}: ascending scan, strict greater
    function automatic logic [31:0] exp_irq();
        logic [NSRC-1:0] r = exp_req();
        int best = -1;
        for (int i = 0; i < NSRC; i++)
            if (r[i] && m_lvl[i] > m_thr && (best < 0 || m_lvl[i] > m_lvl[best]))
                best = i;
        if (best < 0) return 32'd0;
        return {25'd0, 1'b1, 3'(best), 3'(m_lvl[best])};
    endfunction

    task automatic fold_level_dma();
        for (int i = 0; i < NSRC; i++)
            if (m_lvl[i] != 0 && m_dma[i] != 0 && level_active(i))
                exp_dma[m_chan[i]] = 1'b1;
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
        fold_level_dma();
    endtask

    task automatic cfg_src(input int i, input int mode, input int lvl, input int dma, input int chan);
        m_mode[i] = mode; m_lvl[i] = lvl; m_dma[i] = dma; m_chan[i] = chan;
        reg_write(i, (32'(chan) << 12) | (32'(dma) << 8) | (32'(lvl) << 4) | 32'(mode));
    endtask

    task automatic set_thr(input int t);
        m_thr = t;
        reg_write(A_THR, 32'(t));
    endtask

    task automatic clear_all();
        reg_write(A_PEND, 32'hFFFF_FFFF);
        reg_write(A_DMA, 32'hFFFF_FFFF);
        exp_pend = '0;
        exp_dma  = '0;
        settle();
    endtask

    task automatic all_off();
        for (int i = 0; i < NSRC; i++) cfg_src(i, 0, 0, 0, 0);
        set_thr(0);
        clear_all();
    endtask

    task automatic drive(input int i, input bit v);
        @(negedge clk);
        if (edge_matches(m_mode[i], drv[i], v) && m_lvl[i] != 0) begin
            if (m_dma[i] != 0) exp_dma[m_chan[i]] = 1'b1;
            else exp_pend[i] = 1'b1;
        end
        irq_in[i] = v;
        drv[i] = v;
        repeat (4) @(posedge clk);
        @(negedge clk);
        fold_level_dma();
    endtask

    task automatic check_all(input string tag);
        logic [31:0] rd;
        check({tag, " R3 R4 R5 irq output"}, {25'd0, irq_valid, irq_id, irq_level}, exp_irq());
        reg_read(A_PEND, rd);
        check({tag, " R6 request vector"}, rd, 32'(exp_req()));
        reg_read(A_DMA, rd);
        check({tag, " R7 R8 dma flags"}, rd, 32'(exp_dma));
        check({tag, " R8 dma_req port"}, 32'(dma_req), 32'(exp_dma));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd1234));
        for (int i = 0; i < NSRC; i++) begin
            m_mode[i] = 0; m_lvl[i] = 0; m_dma[i] = 0; m_chan[i] = 0; drv[i] = 0;
        end
        m_thr = 0; exp_pend = '0; exp_dma = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 irq_valid after reset", {31'd0, irq_valid}, 32'd0);
        check("R11 irq_id/level after reset", {26'd0, irq_id, irq_level}, 32'd0);
        reg_read(A_THR, rd);  check("R4 R11 threshold resets to 0", rd, 32'd0);
        reg_read(A_DMA, rd);  check("R11 dma flags reset", rd, 32'd0);
        reg_read(3, rd);      check("R11 config word reset", rd, 32'd0);

        // R10 config readback
        cfg_src(5, 3, 6, 1, 2);
        reg_read(5, rd); check("R10 config readback", rd, 32'h0000_2163);
        all_off();

        // R12 latency for a level-high source
        cfg_src(1, 0, 3, 0, 0);
        settle();
        @(negedge clk); irq_in[1] = 1'b1; drv[1] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R12 not yet visible after two edges", {31'd0, irq_valid}, 32'd0);
        @(posedge clk); @(negedge clk);
        check("R12 visible on third edge", {25'd0, irq_valid, irq_id, irq_level}, {25'd0, 1'b1, 3'd1, 3'd3});
        drive(1, 0);
        settle();
        check("R6 level request drops with input", {31'd0, irq_valid}, 32'd0);
        all_off();

        // R3 tie-break and level order
        cfg_src(2, 0, 4, 0, 0);
        cfg_src(5, 0, 4, 0, 0);
        drive(2, 1); drive(5, 1); settle();
        check_all("R3 tie lower index");
        cfg_src(5, 0, 6, 0, 0); settle();
        check_all("R3 higher level wins");
        // R4 threshold equal blocks, lower passes
        set_thr(6); settle();
        check("R4 threshold equal to level blocks", {31'd0, irq_valid}, 32'd0);
        set_thr(5); settle();
        check("R4 level above threshold passes", {25'd0, irq_valid, irq_id, irq_level}, {25'd0, 1'b1, 3'd5, 3'd6});
        // R2 level 0 disables
        cfg_src(5, 0, 0, 0, 0); cfg_src(2, 0, 0, 0, 0); set_thr(0); settle();
        check_all("R2 level 0 disabled");
        drive(2, 0); drive(5, 0);
        all_off();

        // R1 R6 both-edge sticky pending
        cfg_src(1, 4, 2, 0, 0); settle();
        drive(1, 1); settle();
        check_all("R1 R6 both-edge rise latched");
        reg_write(A_PEND, 32'h2); exp_pend[1] = 1'b0; settle();
        check_all("R6 pending cleared by write");
        drive(1, 0); settle();
        check_all("R1 R6 both-edge fall latched");
        all_off();

        // R9 clear in the same cycle as a new edge
        cfg_src(0, 2, 3, 0, 0); settle();
        @(negedge clk); irq_in[0] = 1'b1; drv[0] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(A_PEND); reg_wdata = 32'h1;
        @(negedge clk); reg_we = 1'b0;
        settle();
        check("R9 same-cycle clear drops edge", {31'd0, irq_valid}, 32'd0);
        reg_read(A_PEND, rd); check("R9 pending stays clear", rd, 32'd0);
        drive(0, 0);
        all_off();

        // R7 R8 DMA routing and write-one-to-clear
        cfg_src(3, 2, 5, 1, 2); settle();
        drive(3, 1); settle();
        check_all("R7 dma rise sets channel 2");
        check("R7 no irq in dma mode", {31'd0, irq_valid}, 32'd0);
        reg_write(A_DMA, 32'h4); exp_dma[2] = 1'b0; settle();
        check_all("R8 dma flag cleared");
        drive(3, 0);
        all_off();

        // Random rounds
        for (int r = 0; r < 40; r++) begin
            for (int i = 0; i < NSRC; i++)
                cfg_src(i, $urandom % 8, $urandom % 8, ($urandom % 4) == 0, $urandom % NCH);
            set_thr($urandom % 5);
            clear_all();
            check_all("R1 random configure");
            for (int k = 0; k < 5; k++) begin
                int s = $urandom % NSRC;
                drive(s, !drv[s]);
            end
            settle();
            check_all("R6 random toggles");
            begin
                logic [31:0] w = $urandom;
                reg_write(A_PEND, w); exp_pend &= ~w[NSRC-1:0];
                reg_write(A_DMA, w);  exp_dma  &= ~w[NCH-1:0];
                settle();
                check_all("R8 random partial clear");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule